// File: doc/BRIEF.md
# Multi-Mode Timer/Counter with Selectable Timebase

This block is a general-purpose timer/counter built from two count bytes, a high byte and a low byte. A mode input arranges the bytes into one of four counters. Three of them are a 13-bit counter, a 16-bit counter and an 8-bit counter that reloads itself from the high byte. The fourth is a split arrangement in which the two bytes count independently of each other. Overflow of the main counter raises a sticky flag. In the split arrangement the high byte raises its own separate sticky flag.

Counting is paced by a prescaler that divides the block clock. The default divisor is 12. A fast-select input changes it to 4, and an alternate-select input changes it to 13. In timer operation every prescaler tick advances the count. In counter operation the block instead counts falling edges of an external pin. The pin is first synchronised, then examined once per prescaler tick.

Both count bytes can be read at all times and can be loaded through a single write-data port. Separate run enables gate the main counter and the split high byte.

Top module: `mtc_timer`

## Requirements
- R1: While rst_n is low, cnt_lo, cnt_hi, ovf and ovf_hi are all 0.
- R2: Prescaler divisor is 12 with fast_sel=0 and alt_sel=0, 4 with fast_sel=1 and alt_sel=0, and 13 whenever alt_sel=1 (alt_sel wins over fast_sel). In timer operation (ext_mode=0) with run_en=1, after N clock edges following reset release the count has advanced by exactly floor(N/divisor).
- R3: While run_en=0, the low byte never changes except by a write, and in modes 00, 01 and 10 neither count byte advances.
- R4: Mode 01 (16-bit): {cnt_hi,cnt_lo} increments by one per count event; the wrap from 0xFFFF to 0x0000 sets ovf.
- R5: Mode 00 (13-bit): cnt_lo[4:0] counts, and each wrap of those 5 bits increments cnt_hi; cnt_lo[7:5] keep their written value; the wrap of the 13-bit value {cnt_hi,cnt_lo[4:0]} from all ones to zero sets ovf.
- R6: Mode 10 (8-bit reload): cnt_lo increments, and on passing 0xFF it is loaded with cnt_hi and sets ovf; cnt_hi is left unchanged by counting.
- R7: Mode 11 (split): cnt_lo counts the selected source gated by run_en and sets ovf on its 0xFF wrap; cnt_hi counts prescaler ticks only, gated by hi_run_en, and sets ovf_hi on its 0xFF wrap; ovf_hi is never set in the other modes.
- R8: With ext_mode=1 the count source is falling edges of ext_pin, after a 2-stage synchroniser, sampled on prescaler ticks; each level held for at least one divisor period plus 2 clocks yields exactly one count per falling edge, and prescaler ticks alone do not count.
- R9: ovf stays set until a cycle with clr_ovf=1, and ovf_hi stays set until a cycle with clr_ovf_hi=1; a wrap in the same cycle as the clear leaves the flag set.
- R10: wr_lo (wr_hi) loads wr_data into cnt_lo (cnt_hi) at the next clock edge, taking priority over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 13-bit, 01 16-bit, 10 8-bit reload, 11 split |
| ext_mode | input | 1 | 1 counts ext_pin falling edges, 0 counts prescaler ticks |
| fast_sel | input | 1 | Selects divide-by-4 timebase |
| alt_sel | input | 1 | Selects divide-by-13 timebase (overrides fast_sel) |
| run_en | input | 1 | Gates the main / low-byte counter |
| hi_run_en | input | 1 | Gates the high byte in split mode |
| ext_pin | input | 1 | External count pin, asynchronous |
| wr_lo | input | 1 | Load wr_data into the low byte |
| wr_hi | input | 1 | Load wr_data into the high byte |
| wr_data | input | 8 | Write data for both bytes |
| clr_ovf | input | 1 | Clears the main overflow flag |
| clr_ovf_hi | input | 1 | Clears the split high-byte overflow flag |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf | output | 1 | Sticky main overflow flag |
| ovf_hi | output | 1 | Sticky split high-byte overflow flag |

## Verification
Each timer-mode run begins with a reset. The prescaler phase is therefore known, and after N edges the count must have moved by floor(N/divisor) with no tolerance; the first event lands on edge number divisor, which comes after the two write edges. Writes and flag clears take effect at the next edge, so they are checked one cycle later. A pin edge reaches the count within two synchroniser cycles plus one divisor period; the bench holds each pin level for three periods and checks the count only after the last level has settled. Inputs change and outputs are sampled at the falling clock edge, so every check reads fully registered values.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

   typedef enum logic [1:0] {
      MODE_13     = 2'b00,
      MODE_16     = 2'b01,
      MODE_RELOAD = 2'b10,
      MODE_SPLIT  = 2'b11
   } mtc_mode_e;

endpackage

// File: rtl/mtc_prescaler.sv
module mtc_prescaler #(
   parameter int DIV_SLOW = 12,
   parameter int DIV_FAST = 4,
   parameter int DIV_ALT  = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_sel,
   input  logic alt_sel,
   output logic tick
);
   localparam int DMAX_A = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
   localparam int DMAX   = (DMAX_A > DIV_ALT) ? DMAX_A : DIV_ALT;
   localparam int CW     = $clog2(DMAX);
   localparam logic [CW-1:0] LAST_SLOW = CW'(DIV_SLOW - 1);
   localparam logic [CW-1:0] LAST_FAST = CW'(DIV_FAST - 1);
   localparam logic [CW-1:0] LAST_ALT  = CW'(DIV_ALT - 1);

   if (DIV_SLOW < 2 || DIV_FAST < 2 || DIV_ALT < 2) begin : g_bad_div
      $error("mtc_prescaler: every divisor must be at least 2");
   end

   logic [CW-1:0] phase_q;
   logic [CW-1:0] last_sel;

   always_comb begin
      if (alt_sel)       last_sel = LAST_ALT;
      else if (fast_sel) last_sel = LAST_FAST;
      else               last_sel = LAST_SLOW;
   end

   // >= keeps the phase bounded when the divisor shrinks mid-period
   assign tick = (phase_q >= last_sel);

   always_ff @(posedge clk) begin
      if (!rst_n)    phase_q <= '0;
      else if (tick) phase_q <= '0;
      else           phase_q <= phase_q + CW'(1);
   end

endmodule

// File: rtl/mtc_edge_det.sv
module mtc_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic sample,
   output logic fall
);
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("mtc_edge_det: SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   held_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[0] <= 1'b1;
            else        sync_q[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[i] <= 1'b1;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   // level captured at the previous sample point
   always_ff @(posedge clk) begin
      if (!rst_n)      held_q <= 1'b1;
      else if (sample) held_q <= sync_q[SYNC_STAGES-1];
   end

   assign fall = sample & held_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/mtc_count_core.sv
module mtc_count_core
   import mtc_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int LOW_PRE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mtc_mode_e         mode,
   input  logic              lo_evt,
   input  logic              hi_evt,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              clr_ovf,
   input  logic              clr_ovf_hi,
   output logic [BYTE_W-1:0] cnt_lo,
   output logic [BYTE_W-1:0] cnt_hi,
   output logic              ovf,
   output logic              ovf_hi
);
   localparam int WIDE_W = 2 * BYTE_W;

   if (LOW_PRE_W < 1 || LOW_PRE_W >= BYTE_W) begin : g_bad_pre
      $error("mtc_count_core: LOW_PRE_W must lie in 1..BYTE_W-1");
   end

   logic [BYTE_W-1:0]    lo_q, hi_q, lo_n, hi_n;
   logic                 ovf_q, ovf_hi_q;
   logic                 wrap_main, wrap_hi;
   logic [LOW_PRE_W-1:0] pre_bits;
   logic [WIDE_W-1:0]    wide_sum;

   assign pre_bits = lo_q[LOW_PRE_W-1:0];
   assign wide_sum = {hi_q, lo_q} + WIDE_W'(1);

   always_comb begin
      lo_n      = lo_q;
      hi_n      = hi_q;
      wrap_main = 1'b0;
      wrap_hi   = 1'b0;
      unique case (mode)
         MODE_13: begin
            if (lo_evt) begin
               if (&pre_bits) begin
                  lo_n[LOW_PRE_W-1:0] = '0;
                  hi_n                = hi_q + BYTE_W'(1);
                  wrap_main           = &hi_q;
               end else begin
                  lo_n[LOW_PRE_W-1:0] = pre_bits + LOW_PRE_W'(1);
               end
            end
         end
         MODE_16: begin
            if (lo_evt) begin
               {hi_n, lo_n} = wide_sum;
               wrap_main    = &{hi_q, lo_q};
            end
         end
         MODE_RELOAD: begin
            if (lo_evt) begin
               if (&lo_q) begin
                  lo_n      = hi_q;
                  wrap_main = 1'b1;
               end else begin
                  lo_n = lo_q + BYTE_W'(1);
               end
            end
         end
         MODE_SPLIT: begin
            if (lo_evt) begin
               lo_n      = lo_q + BYTE_W'(1);
               wrap_main = &lo_q;
            end
            if (hi_evt) begin
               hi_n    = hi_q + BYTE_W'(1);
               wrap_hi = &hi_q;
            end
         end
         default: ;
      endcase
      if (wr_lo) lo_n = wr_data;
      if (wr_hi) hi_n = wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q     <= '0;
         hi_q     <= '0;
         ovf_q    <= 1'b0;
         ovf_hi_q <= 1'b0;
      end else begin
         lo_q     <= lo_n;
         hi_q     <= hi_n;
         ovf_q    <= wrap_main | (ovf_q & ~clr_ovf);
         ovf_hi_q <= wrap_hi | (ovf_hi_q & ~clr_ovf_hi);
      end
   end

   assign cnt_lo = lo_q;
   assign cnt_hi = hi_q;
   assign ovf    = ovf_q;
   assign ovf_hi = ovf_hi_q;

endmodule

// File: rtl/mtc_timer.sv
module mtc_timer
   import mtc_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int LOW_PRE_W   = 5,
   parameter int DIV_SLOW    = 12,
   parameter int DIV_FAST    = 4,
   parameter int DIV_ALT     = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              ext_mode,
   input  logic              fast_sel,
   input  logic              alt_sel,
   input  logic              run_en,
   input  logic              hi_run_en,
   input  logic              ext_pin,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              clr_ovf,
   input  logic              clr_ovf_hi,
   output logic [BYTE_W-1:0] cnt_lo,
   output logic [BYTE_W-1:0] cnt_hi,
   output logic              ovf,
   output logic              ovf_hi
);
   logic      tick;
   logic      pin_fall;
   logic      lo_evt;
   logic      hi_evt;
   mtc_mode_e mode_e;

   assign mode_e = mtc_mode_e'(mode);

   mtc_prescaler #(
      .DIV_SLOW (DIV_SLOW),
      .DIV_FAST (DIV_FAST),
      .DIV_ALT  (DIV_ALT)
   ) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .fast_sel (fast_sel),
      .alt_sel  (alt_sel),
      .tick     (tick)
   );

   mtc_edge_det #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (ext_pin),
      .sample (tick),
      .fall   (pin_fall)
   );

   assign lo_evt = run_en & (ext_mode ? pin_fall : tick);
   assign hi_evt = hi_run_en & tick;

   mtc_count_core #(
      .BYTE_W    (BYTE_W),
      .LOW_PRE_W (LOW_PRE_W)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode_e),
      .lo_evt     (lo_evt),
      .hi_evt     (hi_evt),
      .wr_lo      (wr_lo),
      .wr_hi      (wr_hi),
      .wr_data    (wr_data),
      .clr_ovf    (clr_ovf),
      .clr_ovf_hi (clr_ovf_hi),
      .cnt_lo     (cnt_lo),
      .cnt_hi     (cnt_hi),
      .ovf        (ovf),
      .ovf_hi     (ovf_hi)
   );

endmodule

// File: rtl/mtc_timer_chk.sv
module mtc_timer_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              run_en,
   input logic              wr_lo,
   input logic              wr_hi,
   input logic [BYTE_W-1:0] wr_data,
   input logic              clr_ovf,
   input logic              tick,
   input logic [BYTE_W-1:0] cnt_lo,
   input logic [BYTE_W-1:0] cnt_hi,
   input logic              ovf,
   input logic              ovf_hi
);
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   p_lo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !wr_lo) |=> $stable(cnt_lo));

   p_ovf_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(run_en));

   p_reload_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && !wr_hi) |=> $stable(cnt_hi));

   p_ovf_hi_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b11 && !ovf_hi) |=> !ovf_hi);

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_ovf) |=> ovf);

   p_write_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (cnt_lo == $past(wr_data)));

   p_write_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (cnt_hi == $past(wr_data)));

endmodule

bind mtc_timer mtc_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode    (mode),
   .run_en  (run_en),
   .wr_lo   (wr_lo),
   .wr_hi   (wr_hi),
   .wr_data (wr_data),
   .clr_ovf (clr_ovf),
   .tick    (tick),
   .cnt_lo  (cnt_lo),
   .cnt_hi  (cnt_hi),
   .ovf     (ovf),
   .ovf_hi  (ovf_hi)
);

// File: tb/mtc_timer_tb.sv
module mtc_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b01;
   logic       ext_mode = 1'b0, fast_sel = 1'b0, alt_sel = 1'b0;
   logic       run_en = 1'b0, hi_run_en = 1'b0, ext_pin = 1'b1;
   logic       wr_lo = 1'b0, wr_hi = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       clr_ovf = 1'b0, clr_ovf_hi = 1'b0;
   logic [7:0] cnt_lo, cnt_hi;
   logic       ovf, ovf_hi;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   mtc_timer u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .ext_mode(ext_mode),
      .fast_sel(fast_sel), .alt_sel(alt_sel), .run_en(run_en),
      .hi_run_en(hi_run_en), .ext_pin(ext_pin), .wr_lo(wr_lo),
      .wr_hi(wr_hi), .wr_data(wr_data), .clr_ovf(clr_ovf),
      .clr_ovf_hi(clr_ovf_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
      .ovf(ovf), .ovf_hi(ovf_hi)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int div_of(input logic fs, input logic as);
      return as ? 13 : (fs ? 4 : 12);
   endfunction

   // reset, then write lo on edge 1 and hi on edge 2 after release
   task automatic start(input logic [1:0] md, input logic ext, input logic fs,
                        input logic as, input logic run, input logic hrun,
                        input int lo, input int hi);
      @(negedge clk);
      rst_n = 1'b0; mode = md; ext_mode = ext; fast_sel = fs; alt_sel = as;
      run_en = 1'b0; hi_run_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1; run_en = run; hi_run_en = hrun;
      wr_lo = 1'b1; wr_data = lo[7:0];
      @(negedge clk);
      wr_lo = 1'b0; wr_hi = 1'b1; wr_data = hi[7:0];
      @(negedge clk);
      wr_hi = 1'b0;
   endtask

   task automatic run_to(input int n);
      repeat (n - 2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int d, n, ev, v, lo, hi;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 cnt_lo", cnt_lo, 0); chk("R1 cnt_hi", cnt_hi, 0);
      chk("R1 ovf", ovf, 0);       chk("R1 ovf_hi", ovf_hi, 0);

      // R10: written bytes visible before any count event
      start(2'b01, 0, 1, 0, 1, 0, 8'hA5, 8'h5A);
      chk("R10 lo", cnt_lo, 8'hA5); chk("R10 hi", cnt_hi, 8'h5A);

      // R2/R4: 16-bit counting across all timebase selections
      for (int c = 0; c < 4; c++) begin
         for (int j = 0; j < 4; j++) begin
            d = div_of(c[0], c[1]);
            n = (j == 0) ? d - 1 : (j == 1) ? d : (j == 2) ? 3 * d + 1 : 7 * d;
            start(2'b01, 0, c[0], c[1], 1, 0, 8'h34, 8'h12);
            run_to(n);
            v = 16'h1234 + n / d;
            chk("R2/R4 count", {cnt_hi, cnt_lo}, v);
         end
      end

      // R4/R9: 16-bit wrap, sticky flag, clear
      start(2'b01, 0, 1, 0, 1, 0, 8'hFE, 8'hFF);
      run_to(4);
      chk("R4 before wrap", {cnt_hi, cnt_lo}, 16'hFFFF); chk("R4 ovf low", ovf, 0);
      repeat (4) @(negedge clk);
      chk("R4 wrapped", {cnt_hi, cnt_lo}, 0); chk("R4 ovf set", ovf, 1);
      chk("R7 no ovf_hi outside split", ovf_hi, 0);
      repeat (8) @(negedge clk);
      chk("R9 ovf sticky", ovf, 1);
      clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0;
      chk("R9 ovf cleared", ovf, 0);
      rst_n = 1'b0; @(negedge clk);
      chk("R1 cleared by reset", {cnt_hi, cnt_lo}, 0);

      // R5: 13-bit sweep, upper low-byte bits preserved
      for (int k = 0; k < 8; k++) begin
         lo = 8'hBD; hi = 8'hFF;
         start(2'b00, 0, 1, 0, 1, 0, lo, hi);
         run_to(4 * (k * 5));
         ev = k * 5;
         v = ((hi << 5) | (lo & 31)) + ev;
         chk("R5 lo", cnt_lo, (lo & 8'hE0) | (v & 31));
         chk("R5 hi", cnt_hi, (v >> 5) & 8'hFF);
         chk("R5 ovf", ovf, (v > 8191) ? 1 : 0);
      end

      // R6: reload sweep
      for (int k = 1; k < 6; k++) begin
         start(2'b10, 0, 1, 0, 1, 0, 8'hFE, 8'h80);
         run_to(4 * k);
         v = 8'hFE;
         for (int e = 0; e < k; e++) v = (v == 8'hFF) ? 8'h80 : v + 1;
         chk("R6 lo", cnt_lo, v);
         chk("R6 hi unchanged", cnt_hi, 8'h80);
         chk("R6 ovf", ovf, (k >= 2) ? 1 : 0);
      end

      // R7: split mode, both halves counting
      start(2'b11, 0, 1, 0, 1, 1, 8'hFD, 8'hFE);
      run_to(8);
      chk("R7 lo", cnt_lo, 8'hFF); chk("R7 ovf", ovf, 0);
      chk("R7 hi", cnt_hi, 8'h00); chk("R7 ovf_hi", ovf_hi, 1);
      repeat (4) @(negedge clk);
      chk("R7 lo wrap", cnt_lo, 8'h00); chk("R7 ovf main", ovf, 1);
      clr_ovf_hi = 1'b1; @(negedge clk); clr_ovf_hi = 1'b0;
      chk("R9 ovf_hi cleared", ovf_hi, 0); chk("R9 ovf kept", ovf, 1);

      // R7: hi_run_en low freezes high byte
      start(2'b11, 0, 1, 0, 1, 0, 8'h10, 8'h20);
      run_to(40);
      chk("R7 hi gated", cnt_hi, 8'h20); chk("R7 lo runs", cnt_lo, 8'h1A);

      // R3: run_en low in split: low byte frozen, high byte still counts
      start(2'b11, 0, 1, 0, 0, 1, 8'h10, 8'h20);
      run_to(40);
      chk("R3 lo held", cnt_lo, 8'h10); chk("R3/R7 hi runs", cnt_hi, 8'h2A);

      // R3: run_en low in 16-bit mode
      start(2'b01, 0, 0, 0, 0, 0, 8'h77, 8'h66);
      run_to(60);
      chk("R3 16-bit held", {cnt_hi, cnt_lo}, 16'h6677);

      // R8: counter mode, pin idle, then pulses
      ext_pin = 1'b1;
      start(2'b01, 1, 1, 0, 1, 0, 8'h10, 8'h00);
      run_to(40);
      chk("R8 ticks ignored", {cnt_hi, cnt_lo}, 16'h0010);
      for (int p = 0; p < 5; p++) begin
         ext_pin = 1'b0; repeat (12) @(negedge clk);
         ext_pin = 1'b1; repeat (12) @(negedge clk);
      end
      chk("R8 five edges", {cnt_hi, cnt_lo}, 16'h0015);

      // R8: counter mode with divide-by-13
      start(2'b10, 1, 0, 1, 1, 0, 8'hF0, 8'hF0);
      for (int p = 0; p < 3; p++) begin
         ext_pin = 1'b0; repeat (39) @(negedge clk);
         ext_pin = 1'b1; repeat (39) @(negedge clk);
      end
      chk("R8 div13 edges", cnt_lo, 8'hF3);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule